// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit count channels for a small microcontroller. Each channel keeps a low byte and a high byte. It advances either on every machine-cycle strobe (timer function) or on a falling edge seen on its external count pin (counter function). A per-channel mode field chooses one of four count arrangements:

- a 13-bit count made of a 5-bit prescaler below an 8-bit counter;
- a full 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split arrangement in which channel 0 becomes two independent 8-bit counters and channel 1 freezes.

Software reaches the block through a byte-wide register port. On that port it selects the modes, starts and stops each channel and loads or reads the count bytes. Counting can also be gated by an external level pin.

Each channel raises a sticky rollover flag for the interrupt controller. The flag is cleared when the controller acknowledges the vector, or when software writes the flag directly.

Top module: `tmr_pair_unit`

## Requirements
- R1: After reset every count byte, the mode register, the control register and both rollover flags read as zero.
- R2: Register addresses are: 0 = mode, 1 = control, 2/3 = channel 0 low/high byte, 4/5 = channel 1 low/high byte. In the mode register, channel c owns bits [4c+3:4c]. Within that nibble, bits [1:0] are the mode (00 = prescaled 13-bit, 01 = 16-bit, 10 = reload 8-bit, 11 = split/hold), bit 2 selects the external-pin counter function, and bit 3 enables gating. In the control register, bit c is the run bit of channel c and bit 2+c is the rollover flag of channel c.
- R3: In mode 01 the channel counts as one 16-bit value. An advance from 0xFFFF gives 0x0000 and sets the channel's flag.
- R4: In mode 00 the low 5 bits of the low byte act as a prescaler, and the low byte's upper 3 bits stay unchanged. When the prescaler wraps from 31, the high byte advances. A wrap with the high byte at 0xFF sets the flag.
- R5: In mode 10 only the low byte counts. An advance from 0xFF loads the low byte from the high byte, which is left unchanged, and sets the flag.
- R6: While channel 0 is in mode 11, its low byte counts as an 8-bit counter under channel 0's own run, gate and function controls and sets flag 0. Its high byte counts machine cycles whenever run bit 1 is set, and it sets flag 1 when it wraps. Channel 1 keeps counting under its own controls, but its own wraps set no flag.
- R7: While channel 1 is in mode 11, its count bytes hold their value.
- R8: A channel advances at most once per machine-cycle strobe, and only while its run bit is set.
- R9: With the gate bit set, a channel advances only while its gate pin is high.
- R10: In counter function, the pin is sampled on each strobe. A high sample followed by a low sample advances the count on the next strobe. A steady level never advances it.
- R11: An acknowledge pulse clears the channel's flag. A control write loads the flag. A hardware set in the same cycle wins over both.
- R12: A byte write in the same cycle as an advance stores the written value, and the advance of that cycle is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| mc_tick | input | 1 | one-clock machine-cycle strobe |
| wr_en | input | 1 | register write enable |
| wr_addr | input | 3 | register write address |
| wr_data | input | 8 | register write data |
| rd_addr | input | 3 | register read address |
| rd_data | output | 8 | register read data (combinational) |
| cnt_pin | input | 2 | external count pins, one per channel |
| gate_pin | input | 2 | external gate pins, one per channel |
| vec_ack | input | 2 | per-channel vector acknowledge pulse |
| ovf_flag | output | 2 | per-channel rollover flags |

## Verification
The count path is driven with several patterns, each aimed at a different fault:

- Preloaded values placed just below each mode's wrap point separate the four mode arithmetics, the reload source and the flag routing.
- Strobes with the run bit cleared, or with the gate pin low, show whether the qualifiers are actually applied.
- A pin waveform that holds high, then drops, then holds low shows whether the design counts edges rather than levels. It also shows whether the increment lands one strobe after the edge is detected.
- Writes issued in the same cycle as a strobe show which side wins, for both a count byte and the flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int TMR_BW    = 8;
  localparam int TMR_PRE_W = 5;
  localparam int TMR_NCH   = 2;
  localparam int TMR_MF    = 4;

  typedef enum logic [1:0] {
    MD_PRE13   = 2'b00,
    MD_FULL16  = 2'b01,
    MD_RELOAD8 = 2'b10,
    MD_SPLIT   = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic [TMR_BW-1:0] lo;
    logic [TMR_BW-1:0] hi;
    logic              roll;
  } step_t;

  // one advance of a channel in the given mode
  function automatic step_t step_count(tmr_mode_e md, logic [TMR_BW-1:0] lo,
                                       logic [TMR_BW-1:0] hi);
    step_t r;
    logic [TMR_PRE_W-1:0] pre;
    r.lo   = lo;
    r.hi   = hi;
    r.roll = 1'b0;
    pre    = lo[TMR_PRE_W-1:0];
    case (md)
      MD_PRE13: begin
        r.lo[TMR_PRE_W-1:0] = pre + 1'b1;
        if (&pre) begin
          r.hi   = hi + 1'b1;
          r.roll = &hi;
        end
      end
      MD_FULL16: begin
        {r.hi, r.lo} = {hi, lo} + 1'b1;
        r.roll       = &{hi, lo};
      end
      MD_RELOAD8: begin
        if (&lo) begin
          r.lo   = hi;
          r.roll = 1'b1;
        end else begin
          r.lo = lo + 1'b1;
        end
      end
      default: begin
        r.lo   = lo + 1'b1;
        r.roll = &lo;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic s_cur, s_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cur  <= 1'b0;
      s_prev <= 1'b0;
    end else if (tick) begin
      s_cur  <= pin;
      s_prev <= s_cur;
    end
  end

  assign fall = s_prev & ~s_cur;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tmr_mode_e         md,
  input  logic              inc_main,
  input  logic              inc_aux,
  input  logic              hold,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [TMR_BW-1:0] wdata,
  output logic [TMR_BW-1:0] lo_q,
  output logic [TMR_BW-1:0] hi_q,
  output logic              roll_main,
  output logic              roll_aux
);
  step_t             step;
  logic [TMR_BW-1:0] nlo, nhi;
  logic              split, go_main, go_aux;

  always_comb begin
    split   = (md == MD_SPLIT);
    step    = step_count(md, lo_q, hi_q);
    go_main = inc_main && !hold && !wr_lo && !(wr_hi && !split);
    go_aux  = inc_aux && split && !wr_hi;
    roll_main = go_main && step.roll;
    roll_aux  = go_aux && (&hi_q);
    nlo = lo_q;
    nhi = hi_q;
    if (go_main) begin
      nlo = step.lo;
      if (!split) nhi = step.hi;
    end
    if (go_aux) nhi = hi_q + 1'b1;
    if (wr_lo) nlo = wdata;
    if (wr_hi) nhi = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= nlo;
      hi_q <= nhi;
    end
  end
endmodule

// File: rtl/tmr_pair_unit.sv
module tmr_pair_unit
  import tmr_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_tick,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [TMR_BW-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [TMR_BW-1:0] rd_data,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic [1:0]        vec_ack,
  output logic [1:0]        ovf_flag
);
  localparam int A_MODE = 0;
  localparam int A_CTRL = 1;
  localparam int A_CNT  = 2;

  logic [TMR_NCH*TMR_MF-1:0] mode_q;
  logic [TMR_NCH-1:0]        run_q, ovf_q;
  logic [TMR_NCH-1:0]        roll_main, roll_aux, roll_set, fall, ev;
  logic [TMR_NCH-1:0]        wr_lo, wr_hi;
  logic [TMR_BW-1:0]         lo_q [TMR_NCH];
  logic [TMR_BW-1:0]         hi_q [TMR_NCH];
  tmr_mode_e                 md   [TMR_NCH];
  logic [2*TMR_NCH*TMR_BW-1:0] cnt_vec;
  logic                      wr_ctrl, split0;

  assign wr_ctrl = wr_en && (wr_addr == AW'(A_CTRL));
  assign split0  = (md[0] == MD_SPLIT);

  for (genvar c = 0; c < TMR_NCH; c++) begin : g_ch
    logic ext_sel, gate_on, qual;
    assign md[c]   = tmr_mode_e'(mode_q[TMR_MF*c +: 2]);
    assign ext_sel = mode_q[TMR_MF*c + 2];
    assign gate_on = mode_q[TMR_MF*c + 3];
    assign qual    = run_q[c] && (!gate_on || gate_pin[c]);
    assign ev[c]   = mc_tick && qual && (!ext_sel || fall[c]);
    assign wr_lo[c] = wr_en && (wr_addr == AW'(A_CNT + 2*c));
    assign wr_hi[c] = wr_en && (wr_addr == AW'(A_CNT + 2*c + 1));

    tmr_fall_det u_fall (
      .clk (clk), .rst_n(rst_n), .tick(mc_tick), .pin(cnt_pin[c]), .fall(fall[c])
    );

    tmr_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .md       (md[c]),
      .inc_main (ev[c]),
      .inc_aux  ((c == 0) ? (mc_tick && run_q[1]) : 1'b0),
      .hold     ((c == 1) && (md[c] == MD_SPLIT)),
      .wr_lo    (wr_lo[c]),
      .wr_hi    (wr_hi[c]),
      .wdata    (wr_data),
      .lo_q     (lo_q[c]),
      .hi_q     (hi_q[c]),
      .roll_main(roll_main[c]),
      .roll_aux (roll_aux[c])
    );

    assign cnt_vec[2*TMR_BW*c +: 2*TMR_BW] = {hi_q[c], lo_q[c]};
  end

  // flag 1 is owned by channel 0's high byte while channel 0 is split
  always_comb begin
    roll_set    = roll_main;
    roll_set[1] = split0 ? roll_aux[0] : roll_main[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      ovf_q  <= '0;
    end else begin
      if (wr_en && (wr_addr == AW'(A_MODE))) mode_q <= wr_data;
      if (wr_ctrl) run_q <= wr_data[TMR_NCH-1:0];
      for (int c = 0; c < TMR_NCH; c++) begin
        if (roll_set[c])     ovf_q[c] <= 1'b1;
        else if (wr_ctrl)    ovf_q[c] <= wr_data[TMR_NCH + c];
        else if (vec_ack[c]) ovf_q[c] <= 1'b0;
      end
    end
  end

  assign ovf_flag = ovf_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(A_MODE):      rd_data = mode_q;
      AW'(A_CTRL):      rd_data = TMR_BW'({ovf_q, run_q});
      AW'(A_CNT):       rd_data = lo_q[0];
      AW'(A_CNT + 1):   rd_data = hi_q[0];
      AW'(A_CNT + 2):   rd_data = lo_q[1];
      AW'(A_CNT + 3):   rd_data = hi_q[1];
      default:          rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mc_tick,
  input logic        wr_en,
  input logic [1:0]  vec_ack,
  input logic [1:0]  ovf_flag,
  input logic [1:0]  roll_set,
  input logic [31:0] cnt_vec
);
  assert_flag0_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    roll_set[0] |=> ovf_flag[0]);

  assert_flag1_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    roll_set[1] |=> ovf_flag[1]);

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mc_tick && !wr_en) |=> $stable(cnt_vec));

  assert_roll_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_tick |-> (roll_set == 2'b00));

  assert_ack_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack[0] && !roll_set[0] && !wr_en) |=> !ovf_flag[0]);
endmodule

bind tmr_pair_unit tmr_pair_chk u_chk (.*);

// File: tb/test_tmr_pair_unit.sv
`timescale 1ns/1ps
module test_tmr_pair_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [1:0] cnt_pin = '0, gate_pin = '0, vec_ack = '0, ovf_flag;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         flg_q [$];
  event       item_ev;

  always #4 clk = ~clk;

  tmr_pair_unit i_tmr_pair_unit (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pin(cnt_pin),
    .gate_pin(gate_pin), .vec_ack(vec_ack), .ovf_flag(ovf_flag)
  );

  // monitor: pops expected items and compares them with the observed port value
  initial begin
    forever begin
      @(item_ev);
      while (exp_q.size() > 0) begin
        logic [7:0] e, a;
        string t;
        bit f;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        f = flg_q.pop_front();
        a = f ? {6'b0, ovf_flag} : rd_data;
        tests++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  // driver side: address 7 stands for the flag port
  task automatic expect_val(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    rd_addr = (a == 3'd7) ? 3'd0 : a;
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    flg_q.push_back(a == 3'd7);
    ->item_ev;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; mc_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; mc_tick = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mc_tick = 1'b1;
      @(negedge clk); mc_tick = 1'b0;
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) expect_val(3'(a), 8'h00, "R1 reset register");
    expect_val(3'd7, 8'h00, "R1 reset flags");

    // R3 16-bit mode wrap
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd0, 8'h01); wr(3'd1, 8'h01);
    tick(1);
    expect_val(3'd2, 8'hFF, "R3 low byte");
    expect_val(3'd3, 8'hFF, "R3 high byte");
    tick(1);
    expect_val(3'd2, 8'h00, "R3 wrap low");
    expect_val(3'd3, 8'h00, "R3 wrap high");
    expect_val(3'd7, 8'h01, "R3 flag set");
    expect_val(3'd1, 8'h05, "R2 control layout");
    // R11 acknowledge clears
    @(negedge clk); vec_ack = 2'b01;
    @(negedge clk); vec_ack = 2'b00;
    expect_val(3'd7, 8'h00, "R11 ack clear");
    // R8 run bit off
    wr(3'd1, 8'h00);
    tick(3);
    expect_val(3'd2, 8'h00, "R8 stopped");

    // R4 prescaled mode
    wr(3'd0, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'h05); wr(3'd1, 8'h01);
    tick(1);
    expect_val(3'd2, 8'hE0, "R4 prescaler wrap keeps top bits");
    expect_val(3'd3, 8'h06, "R4 high advance");
    tick(1);
    expect_val(3'd2, 8'hE1, "R4 prescaler step");
    wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
    tick(1);
    expect_val(3'd3, 8'h00, "R4 full wrap");
    expect_val(3'd7, 8'h01, "R4 flag");
    wr(3'd1, 8'h01);
    expect_val(3'd7, 8'h00, "R11 software clear");

    // R5 reload mode
    wr(3'd0, 8'h02); wr(3'd3, 8'h80); wr(3'd2, 8'hFE);
    tick(2);
    expect_val(3'd2, 8'h80, "R5 reload");
    expect_val(3'd7, 8'h01, "R5 flag");
    tick(1);
    expect_val(3'd2, 8'h81, "R5 after reload");
    expect_val(3'd3, 8'h80, "R5 high kept");
    wr(3'd1, 8'h01);

    // R9 gate
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    tick(2);
    expect_val(3'd2, 8'h00, "R9 gate low blocks");
    gate_pin = 2'b01;
    tick(2);
    expect_val(3'd2, 8'h02, "R9 gate high counts");
    gate_pin = 2'b00;

    // R10 counter function
    wr(3'd0, 8'h05); wr(3'd2, 8'h00);
    cnt_pin = 2'b01;
    tick(2);
    expect_val(3'd2, 8'h00, "R10 steady high");
    cnt_pin = 2'b00;
    tick(1);
    expect_val(3'd2, 8'h00, "R10 not yet");
    tick(1);
    expect_val(3'd2, 8'h01, "R10 edge counted");
    tick(1);
    expect_val(3'd2, 8'h01, "R10 steady low");

    // R6 split mode
    wr(3'd0, 8'h13); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr(3'd4, 8'h10); wr(3'd5, 8'h00); wr(3'd1, 8'h03);
    tick(1);
    expect_val(3'd2, 8'h00, "R6 low wrap");
    expect_val(3'd3, 8'h00, "R6 high wrap");
    expect_val(3'd7, 8'h03, "R6 both flags");
    expect_val(3'd4, 8'h11, "R6 channel 1 counts");
    wr(3'd1, 8'h02);
    tick(1);
    expect_val(3'd2, 8'h00, "R6 low needs run 0");
    expect_val(3'd3, 8'h01, "R6 high under run 1");
    expect_val(3'd4, 8'h12, "R6 channel 1");
    expect_val(3'd7, 8'h00, "R6 no flag");

    // R7 channel 1 hold
    wr(3'd0, 8'h31); wr(3'd1, 8'h03);
    tick(2);
    expect_val(3'd4, 8'h12, "R7 hold low");
    expect_val(3'd5, 8'h00, "R7 hold high");

    // R12 write collision
    wr(3'd0, 8'h01); wr(3'd1, 8'h01); wr(3'd2, 8'h40);
    wr_tick(3'd2, 8'h77);
    expect_val(3'd2, 8'h77, "R12 write wins");
    tick(1);
    expect_val(3'd2, 8'h78, "R12 next advance");

    // R11 hardware set beats software clear, software set
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    wr_tick(3'd1, 8'h01);
    expect_val(3'd7, 8'h01, "R11 hardware wins");
    wr(3'd1, 8'h08);
    expect_val(3'd7, 8'h02, "R11 software load");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule